// File: doc/BRIEF.md
# Float to Signed Integer Truncator

This block turns a floating-point operand that has already been unpacked into a 32-bit two's-complement integer. The operand comes in as separate fields: a class code, a sign, a signed unbiased exponent, a mantissa and a sticky bit. The mantissa has its leading one at the top bit and two extra bits (guard, then round) at the bottom. The conversion always truncates toward zero. It never adds one to the magnitude, whatever rounding mode the rest of the floating-point unit uses. The block reports an inexact flag when any fractional part was dropped. It reports an invalid flag when the operand cannot be represented, and in that case it returns a saturated value.

The block is used at the end of a float-to-integer conversion path. The caller presents an operand with `in_valid` high for one cycle. The integer and the two flags appear on the outputs one clock later, together with a one-cycle `out_valid` pulse. The outputs keep their value until the next accepted operand.

Top module: `ftoi_trunc`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid`, `out_inexact` and `out_invalid` are 0 and `out_result` is 0.
- R2: An operand accepted with `in_valid` high at a clock edge produces its result and flags at that same edge, so they are visible in the following cycle. `out_valid` is high for exactly the cycles that follow an edge with `in_valid` high. At an edge with `in_valid` low, the result and the flags keep their previous value.
- R3: Class code 0 (zero) gives result 0 with both flags clear, whatever the sign, exponent, mantissa and sticky inputs are.
- R4: For class code 1 (number), the mantissa value is taken as the leading one at bit MANT_W-1 weighted 2^exponent. The result magnitude is the integer part of that value, cut toward zero with no increment.
- R5: Inexact is set for a representable number when any discarded mantissa bit is 1, including the guard and round bits at bits 1 and 0. It is also set when the sticky input is 1.
- R6: A negative exponent gives magnitude 0, including shifts as wide as the mantissa or wider. Inexact is then set when the mantissa or the sticky input is nonzero.
- R7: A number with exponent 32 or more overflows, whatever its mantissa.
- R8: A number whose truncated magnitude is 0x80000000 or more overflows when positive. A negative number overflows only when the magnitude is above 0x80000000, so -2^31 converts exactly.
- R9: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and every unused code 5 to 7 are treated as overflow.
- R10: On overflow the result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1. Invalid is set and inexact is cleared, even when fraction bits were lost.
- R11: A representable negative number returns the two's-complement negation of its truncated magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent of the leading mantissa bit |
| in_mant | input | MANT_W | Mantissa, leading one at the top, guard and round bits at bits 1 and 0 |
| in_sticky | input | 1 | OR of bits already below the round bit |
| out_valid | output | 1 | Result valid pulse, one cycle after acceptance |
| out_result | output | 32 | Truncated two's-complement integer |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_invalid | output | 1 | Operand not representable; result saturated |

## Verification
On every cycle the assertions check that the valid pulse is timed correctly and that idle cycles leave the held result alone. They also check that the two flags are never both set, that any invalid result is one of the two saturation codes with the sign of the operand, and that zero-class operands and operands that are not numbers map to their fixed outcomes. The exact truncated value cannot be checked by a property. Only the bench's scenarios show it: the sign-dependent edge at 2^31, the lost guard, round and sticky bits, and shifts wider than the mantissa.

// File: rtl/ftoi_pkg.sv
// Package ftoi_pkg
// Shared class codes for the float-to-integer truncator.
// Assumes the unpacking stage uses the same 3-bit encoding.
package ftoi_pkg;

    typedef enum logic [2:0] {
        FC_ZERO = 3'd0,
        FC_NUM  = 3'd1,
        FC_INF  = 3'd2,
        FC_QNAN = 3'd3,
        FC_SNAN = 3'd4
    } fclass_e;

endpackage

// File: rtl/ftoi_align.sv
// Module ftoi_align
// Shifts the mantissa right so that its integer part lands in the low bits,
// and reports whether any set bit fell off the bottom.
// Assumes the leading one sits at bit MANT_W-1 and is weighted 2^exp.
// A non-positive shift (huge exponent) returns all ones; the caller treats
// such exponents as overflow before it uses the magnitude.
module ftoi_align #(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 12
) (
    input  logic signed [EXP_W-1:0]  exp_i,
    input  logic        [MANT_W-1:0] mant_i,
    output logic        [MANT_W-1:0] mag_o,
    output logic                     lost_o
);
    localparam int SHW = EXP_W + 2;
    localparam int CW  = $clog2(MANT_W + 1);
    localparam logic signed [SHW-1:0] TOP_POS = SHW'(MANT_W - 1);
    localparam logic signed [SHW-1:0] FULL    = SHW'(MANT_W);

    logic signed [SHW-1:0] sh;
    logic        [CW-1:0]  shamt;
    logic        [MANT_W-1:0] keep_mask;

    // Distance from the leading bit to the units position.
    always_comb begin
        sh    = TOP_POS - SHW'(exp_i);
        shamt = sh[CW-1:0];
    end

    // Select between saturated, wiped-out and partially shifted magnitude.
    always_comb begin
        keep_mask = '1;
        if (sh <= 0) begin
            mag_o  = '1;
            lost_o = 1'b0;
        end else if (sh >= FULL) begin
            mag_o  = '0;
            lost_o = |mant_i;
        end else begin
            keep_mask = ~({MANT_W{1'b1}} << shamt);
            mag_o     = mant_i >> shamt;
            lost_o    = |(mant_i & keep_mask);
        end
    end

endmodule

// File: rtl/ftoi_pack.sv
// Module ftoi_pack
// Decides overflow from class, exponent and truncated magnitude, applies the
// sign and forms the inexact and invalid flags.
// Assumes MANT_W >= INT_W + 2 so that an exponent below INT_W always leaves
// a magnitude below 2^INT_W.
module ftoi_pack
    import ftoi_pkg::*;
#(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 12,
    parameter int INT_W  = 32
) (
    input  logic [2:0]               class_i,
    input  logic                     sign_i,
    input  logic signed [EXP_W-1:0]  exp_i,
    input  logic        [MANT_W-1:0] mag_i,
    input  logic                     lost_i,
    input  logic                     sticky_i,
    output logic        [INT_W-1:0]  result_o,
    output logic                     inexact_o,
    output logic                     invalid_o
);
    localparam logic signed [EXP_W-1:0] EXP_LIMIT = EXP_W'(INT_W);
    localparam logic [INT_W-1:0] HALF_RANGE = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] POS_SAT    = {1'b0, {(INT_W-1){1'b1}}};

    logic [INT_W-1:0] mag_w;
    logic             too_big;
    logic             ovf;

    // Compare the truncated magnitude against the sign-dependent limit.
    always_comb begin
        mag_w   = mag_i[INT_W-1:0];
        too_big = (exp_i >= EXP_LIMIT) ||
                  (mag_w > HALF_RANGE) ||
                  ((mag_w == HALF_RANGE) && !sign_i);
    end

    // Map the class to an outcome and build result and flags.
    always_comb begin
        result_o  = '0;
        inexact_o = 1'b0;
        invalid_o = 1'b0;
        ovf       = 1'b0;
        unique case (class_i)
            FC_ZERO: ;
            FC_NUM:  ovf = too_big;
            default: ovf = 1'b1;
        endcase
        if (ovf) begin
            result_o  = sign_i ? HALF_RANGE : POS_SAT;
            invalid_o = 1'b1;
        end else if (class_i == FC_NUM) begin
            result_o  = sign_i ? (~mag_w + 1'b1) : mag_w;
            inexact_o = lost_i | sticky_i;
        end
    end

endmodule

// File: rtl/ftoi_trunc.sv
// Module ftoi_trunc
// Top of the float-to-integer truncator: aligns the mantissa, packs the
// integer and registers result and flags one cycle after an accepted input.
// Assumes operands are already unpacked and that MANT_W >= INT_W + 2.
module ftoi_trunc
    import ftoi_pkg::*;
#(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [2:0]               in_class,
    input  logic                     in_sign,
    input  logic signed [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0]        in_mant,
    input  logic                     in_sticky,
    output logic                     out_valid,
    output logic [31:0]              out_result,
    output logic                     out_inexact,
    output logic                     out_invalid
);
    localparam int INT_W = 32;

    logic [MANT_W-1:0] mag;
    logic              lost;
    logic [INT_W-1:0]  res_c;
    logic              nx_c;
    logic              nv_c;

    ftoi_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .exp_i  (in_exp),
        .mant_i (in_mant),
        .mag_o  (mag),
        .lost_o (lost)
    );

    ftoi_pack #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_pack (
        .class_i   (in_class),
        .sign_i    (in_sign),
        .exp_i     (in_exp),
        .mag_i     (mag),
        .lost_i    (lost),
        .sticky_i  (in_sticky),
        .result_o  (res_c),
        .inexact_o (nx_c),
        .invalid_o (nv_c)
    );

    // Valid pulse follows each accepted operand by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture result and flags on accept, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
        end else if (in_valid) begin
            out_result  <= res_c;
            out_inexact <= nx_c;
            out_invalid <= nv_c;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) &&
                       $stable(out_inexact) && $stable(out_invalid)));
    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_inexact && out_invalid));
    // R10
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_invalid ||
            (out_result == ($past(in_sign) ? 32'h8000_0000 : 32'h7FFF_FFFF))));
    // R3
    zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == FC_ZERO) |=>
            (out_result == '0 && !out_inexact && !out_invalid));
    // R9
    nonnum_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class != FC_ZERO && in_class != FC_NUM) |=> out_invalid);
    // R7
    big_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == FC_NUM && in_exp >= EXP_W'(INT_W)) |=> out_invalid);

endmodule

// File: tb/ftoi_trunc_tb.sv
module ftoi_trunc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 40;
    localparam int EW = 12;

    typedef struct packed {
        logic [2:0]    cls;
        logic          sgn;
        logic [EW-1:0] ex;
        logic [MW-1:0] mt;
        logic          stk;
        logic [31:0]   res;
        logic          nx;
        logic          nv;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [0:NV-1] = '{
        '{3'd1, 1'b0, 12'd0,   40'h80_0000_0000, 1'b0, 32'h0000_0001, 1'b0, 1'b0, 4'd4},  // R4 1.0
        '{3'd1, 1'b0, 12'd0,   40'hC0_0000_0000, 1'b0, 32'h0000_0001, 1'b1, 1'b0, 4'd4},  // R4 1.5
        '{3'd1, 1'b1, 12'd0,   40'hC0_0000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd11}, // R11 -1.5
        '{3'd1, 1'b0, 12'd2,   40'hA0_0000_0000, 1'b0, 32'h0000_0005, 1'b0, 1'b0, 4'd4},  // R4 5
        '{3'd1, 1'b1, 12'd2,   40'hA0_0000_0000, 1'b0, 32'hFFFF_FFFB, 1'b0, 1'b0, 4'd11}, // R11 -5
        '{3'd1, 1'b0, 12'd1,   40'hC0_0000_0000, 1'b1, 32'h0000_0003, 1'b1, 1'b0, 4'd5},  // R5 sticky only
        '{3'd1, 1'b0, 12'd1,   40'hC0_0000_0002, 1'b0, 32'h0000_0003, 1'b1, 1'b0, 4'd5},  // R5 guard only
        '{3'd1, 1'b0, 12'd1,   40'hC0_0000_0001, 1'b0, 32'h0000_0003, 1'b1, 1'b0, 4'd5},  // R5 round only
        '{3'd1, 1'b0, 12'hFFF, 40'hC0_0000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd6},  // R6 0.75
        '{3'd1, 1'b1, 12'hF9C, 40'h80_0000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd6},  // R6 tiny
        '{3'd1, 1'b0, 12'hFFF, 40'hFF_FFFF_FFFF, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 4'd6},  // R6 0.99..
        '{3'd1, 1'b0, 12'd30,  40'hFF_FFFF_FE00, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b0, 4'd8},  // R8 2^31-1
        '{3'd1, 1'b0, 12'd30,  40'hFF_FFFF_FFFF, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0, 4'd8},  // R8 below edge
        '{3'd1, 1'b0, 12'd31,  40'h80_0000_0000, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd8},  // R8 +2^31
        '{3'd1, 1'b1, 12'd31,  40'h80_0000_0000, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 4'd8},  // R8 -2^31
        '{3'd1, 1'b1, 12'd31,  40'h80_0000_0100, 1'b0, 32'h8000_0000, 1'b0, 1'b1, 4'd8},  // R8 -(2^31+1)
        '{3'd1, 1'b0, 12'd31,  40'h80_0000_0080, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd10}, // R10 nx cleared
        '{3'd1, 1'b1, 12'd31,  40'h80_0000_0000, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 4'd5},  // R5 -2^31 sticky
        '{3'd1, 1'b0, 12'd32,  40'h80_0000_0000, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd7},  // R7 exp 32
        '{3'd1, 1'b1, 12'd200, 40'hC0_0000_0000, 1'b1, 32'h8000_0000, 1'b0, 1'b1, 4'd7},  // R7 exp 200
        '{3'd2, 1'b0, 12'd0,   40'h00_0000_0000, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd9},  // R9 +inf
        '{3'd3, 1'b1, 12'd5,   40'hC0_0000_0000, 1'b1, 32'h8000_0000, 1'b0, 1'b1, 4'd9},  // R9 qnan
        '{3'd4, 1'b0, 12'd5,   40'h80_0000_0001, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1, 4'd9},  // R9 snan
        '{3'd0, 1'b1, 12'd9,   40'hFF_0000_0003, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 4'd3}   // R3 zero class
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_class = '0;
    logic          in_sign = 1'b0;
    logic [EW-1:0] in_exp = '0;
    logic [MW-1:0] in_mant = '0;
    logic          in_sticky = 1'b0;
    logic          out_valid;
    logic [31:0]   out_result;
    logic          out_inexact;
    logic          out_invalid;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ftoi_trunc #(.MANT_W(MW), .EXP_W(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .in_sticky(in_sticky), .out_valid(out_valid), .out_result(out_result),
        .out_inexact(out_inexact), .out_invalid(out_invalid)
    );

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got valid/nx/nv/result=%h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_class  = v.cls;
        in_sign   = v.sgn;
        in_exp    = v.ex;
        in_mant   = v.mt;
        in_sticky = v.stk;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog: got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while held
        check("R1", {out_valid, out_inexact, out_invalid, out_result}, 35'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 first cycle after release
        check("R1", {out_valid, out_inexact, out_invalid, out_result}, 35'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check($sformatf("R%0d vec%0d", VEC[i].rq, i),
                  {out_valid, out_inexact, out_invalid, out_result},
                  {1'b1, VEC[i].nx, VEC[i].nv, VEC[i].res});
        end

        // R9 unused class codes
        for (int c = 5; c < 8; c++) begin
            drive('{3'(c), 1'b1, 12'd3, 40'h80_0000_0000, 1'b1, 32'h0, 1'b0, 1'b0, 4'd9});
            check("R9 unused code", {out_valid, out_inexact, out_invalid, out_result},
                  {1'b1, 1'b0, 1'b1, 32'h8000_0000});
        end

        // R2 hold when idle: changing inputs without valid has no effect
        drive('{3'd1, 1'b1, 12'd4, 40'hB0_0000_0000, 1'b0, 32'h0, 1'b0, 1'b0, 4'd2});
        check("R2 load", {out_valid, out_inexact, out_invalid, out_result},
              {1'b1, 1'b0, 1'b0, 32'hFFFF_FFEA});
        in_class = 3'd2;
        in_sign  = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 hold", {out_valid, out_inexact, out_invalid, out_result},
              {1'b0, 1'b0, 1'b0, 32'hFFFF_FFEA});

        // R2 back-to-back operands
        @(negedge clk);
        in_valid = 1'b1; in_class = 3'd1; in_sign = 1'b0; in_exp = 12'd3;
        in_mant = 40'h90_0000_0000; in_sticky = 1'b0;
        @(negedge clk);
        check("R2 b2b first", {out_valid, out_inexact, out_invalid, out_result},
              {1'b1, 1'b0, 1'b0, 32'h0000_0009});
        in_class = 3'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b second", {out_valid, out_inexact, out_invalid, out_result},
              {1'b1, 1'b0, 1'b0, 32'h0000_0000});
        @(negedge clk);
        check("R2 pulse ends", {31'd0, out_valid}, 32'd0);

        // R1 reset mid-run clears held state
        drive('{3'd2, 1'b0, 12'd0, 40'h0, 1'b0, 32'h0, 1'b0, 1'b0, 4'd1});
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {out_valid, out_inexact, out_invalid, out_result}, 35'd0);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule